// File: doc/BRIEF.md
# Byte-Serial Instruction Sequencer

This block is the control core of a small 8-bit processor that talks to a single shared memory over a 16-bit address bus and an 8-bit data bus. It steps through one-, two- or three-byte instructions one byte at a time. Every memory access is staged through two registers: an address holding register, which drives the address pins, and a byte holding register, which captures read data and supplies write data. A small opcode table picks each instruction's length and what it does. Operand bytes are moved into the working register W, the scratch register TEMP or the general register B.

After its operands are in place, a three-byte instruction uses {TEMP, W} as a 16-bit address in one of three ways. A load reads that location into W. A store writes B to that location. A jump copies the pair into the program counter, either always or when the selected flag condition holds. The zero, carry and negative flags come in from the arithmetic unit, which sits outside this block. W, TEMP, B and the program counter are brought out so that the surrounding datapath can use them.

The memory has one cycle of read latency. Data comes back in the cycle after the read strobe and is captured at the end of that cycle. Each instruction byte therefore takes four cycles: load the address, strobe, capture, move.

Top module: `instr_fetch_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the program counter, W, TEMP and B become zero and both strobes stay low. The first bus access after reset is a read at address 0x0000.
- R2: Each instruction byte is read from the address held in the program counter. The program counter advances by one for every instruction byte read, carrying from the low byte into the high byte.
- R3: Instruction length is taken from the first byte. Opcodes 0x01 and 0x02 are two bytes long. Opcodes 0x10, 0x11 and 0x20 to 0x26 are three bytes long. The read of the next opcode follows the last operand byte of the instruction.
- R4: Opcode 0x01 loads its second byte into W. Opcode 0x02 loads its second byte into B.
- R5: In a three-byte instruction, the second byte lands in W (low address) and the third byte lands in TEMP (high address).
- R6: Opcode 0x10 performs one read at address {TEMP, W} and places the returned byte in W.
- R7: Opcode 0x11 performs one write at address {TEMP, W}, with mem_wdata equal to B.
- R8: Opcodes 0x20 to 0x26 are jumps with these conditions: 0x20 always, 0x21 zero set, 0x22 zero clear, 0x23 carry set, 0x24 carry clear, 0x25 negative clear, 0x26 negative set. When the condition holds, the next opcode is read from {TEMP, W}.
- R9: A jump whose condition does not hold continues with the opcode at the jump's own address plus three.
- R10: mem_rd and mem_wr are never high together, and neither stays high for two consecutive cycles.
- R11: Any opcode not listed above is a one-byte instruction. It causes no bus access other than its own fetch and leaves W, TEMP and B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 8 | Read data, valid in the cycle after mem_rd |
| flag_zero | input | 1 | Zero flag from the arithmetic unit |
| flag_carry | input | 1 | Carry flag from the arithmetic unit |
| flag_neg | input | 1 | Negative flag from the arithmetic unit |
| mem_addr | output | 16 | Memory address, driven by the address holding register |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_wdata | output | 8 | Write data, driven by the byte holding register |
| reg_w | output | 8 | Working register W |
| reg_temp | output | 8 | Scratch register TEMP |
| reg_b | output | 8 | General register B |
| pc_out | output | 16 | Program counter {high byte, low byte} |

## Verification
Two loads fall into the same cycle when a store begins: the address holding register takes {TEMP, W} while the byte holding register takes B. A mistake in either one would put a wrong address or a wrong byte on the bus during the write strobe. The test provokes this by running a store straight after the instructions that set B, W and TEMP, and again at address 0xFFFF straight after a chain of jumps. The scoreboard judges each write strobe by comparing its address and its data with the expected entry together.

// File: rtl/ifs_pkg.sv
// Package: shared opcode values, decode record, condition codes, FSM states
// and the control-line bundle for the instruction sequencer.
package ifs_pkg;

    localparam logic [7:0] OPC_LDW  = 8'h01;
    localparam logic [7:0] OPC_LDB  = 8'h02;
    localparam logic [7:0] OPC_LOAD = 8'h10;
    localparam logic [7:0] OPC_STOR = 8'h11;
    localparam logic [7:0] OPC_JMP  = 8'h20;
    localparam logic [7:0] OPC_JZ   = 8'h21;
    localparam logic [7:0] OPC_JNZ  = 8'h22;
    localparam logic [7:0] OPC_JC   = 8'h23;
    localparam logic [7:0] OPC_JNC  = 8'h24;
    localparam logic [7:0] OPC_JPOS = 8'h25;
    localparam logic [7:0] OPC_JNEG = 8'h26;

    typedef enum logic [2:0] {
        ACT_NOP, ACT_LDW, ACT_LDB, ACT_LOAD, ACT_STOR, ACT_JUMP
    } act_e;

    typedef enum logic [2:0] {
        CND_ALWAYS, CND_Z, CND_NZ, CND_C, CND_NC, CND_POS, CND_NEG
    } cnd_e;

    typedef struct packed {
        logic [1:0] len;
        act_e       act;
        cnd_e       cnd;
    } dec_t;

    typedef enum logic [3:0] {
        ST_OP_ADR, ST_OP_RD, ST_OP_CAP, ST_OP_DEC,
        ST_BY_ADR, ST_BY_RD, ST_BY_CAP, ST_BY_MOV,
        ST_MR_ADR, ST_MR_RD, ST_MR_CAP, ST_MR_MOV,
        ST_MW_ADR, ST_MW_WR, ST_JMP
    } fsm_e;

    typedef struct packed {
        logic ab_pc;   // address holder <= program counter
        logic ab_wt;   // address holder <= {TEMP, W}
        logic rd;      // read strobe
        logic wr;      // write strobe
        logic db_cap;  // byte holder <= read data
        logic db_b;    // byte holder <= B
        logic ir_ld;   // instruction register <= byte holder
        logic dec_db;  // decode from byte holder instead of instruction register
        logic pc_inc;  // program counter + 1
        logic pc_ld;   // program counter <= {TEMP, W}
        logic w_ld;    // W <= byte holder
        logic t_ld;    // TEMP <= byte holder
        logic b_ld;    // B <= byte holder
    } ctl_t;

endpackage

// File: rtl/ifs_decode.sv
// Module: opcode table. Maps an opcode byte to its length, action and jump
// condition. Assumes 8-bit opcodes; anything unlisted is a one-byte no-op.
module ifs_decode
    import ifs_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    // Combinational table lookup.
    always_comb begin
        dec = '{len: 2'd1, act: ACT_NOP, cnd: CND_ALWAYS};
        case (opcode)
            OPC_LDW:  dec = '{len: 2'd2, act: ACT_LDW,  cnd: CND_ALWAYS};
            OPC_LDB:  dec = '{len: 2'd2, act: ACT_LDB,  cnd: CND_ALWAYS};
            OPC_LOAD: dec = '{len: 2'd3, act: ACT_LOAD, cnd: CND_ALWAYS};
            OPC_STOR: dec = '{len: 2'd3, act: ACT_STOR, cnd: CND_ALWAYS};
            OPC_JMP:  dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_ALWAYS};
            OPC_JZ:   dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_Z};
            OPC_JNZ:  dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_NZ};
            OPC_JC:   dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_C};
            OPC_JNC:  dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_NC};
            OPC_JPOS: dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_POS};
            OPC_JNEG: dec = '{len: 2'd3, act: ACT_JUMP, cnd: CND_NEG};
            default:  dec = '{len: 2'd1, act: ACT_NOP,  cnd: CND_ALWAYS};
        endcase
    end

endmodule

// File: rtl/ifs_cond.sv
// Module: jump condition evaluator. Combines the selected condition code with
// the flags from the arithmetic unit. Assumes flags are stable during a jump.
module ifs_cond
    import ifs_pkg::*;
(
    input  cnd_e cnd,
    input  logic flag_zero,
    input  logic flag_carry,
    input  logic flag_neg,
    output logic take
);

    // Select the flag test named by the condition code.
    always_comb begin
        case (cnd)
            CND_ALWAYS: take = 1'b1;
            CND_Z:      take = flag_zero;
            CND_NZ:     take = !flag_zero;
            CND_C:      take = flag_carry;
            CND_NC:     take = !flag_carry;
            CND_POS:    take = !flag_neg;
            CND_NEG:    take = flag_neg;
            default:    take = 1'b0;
        endcase
    end

endmodule

// File: rtl/ifs_pc.sv
// Module: program counter held as a low and a high byte. Increments with carry
// across the bytes, or loads both bytes at once. Load wins over increment.
module ifs_pc #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_lo,
    input  logic [DATA_W-1:0] ld_hi,
    output logic [ADDR_W-1:0] pc
);

    logic [DATA_W-1:0] pcl_q, pch_q;

    // Byte-wise program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcl_q <= '0;
            pch_q <= '0;
        end else if (ld) begin
            pcl_q <= ld_lo;
            pch_q <= ld_hi;
        end else if (inc) begin
            {pch_q, pcl_q} <= {pch_q, pcl_q} + 1'b1;
        end
    end

    assign pc = {pch_q, pcl_q};

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> pc == ADDR_W'($past(pc) + 1'b1));

endmodule

// File: rtl/ifs_ctrl.sv
// Module: multicycle sequencer. Walks each instruction byte through
// address-load, strobe, capture and move, then runs the data access or jump.
// Assumes memory returns read data one cycle after the read strobe.
module ifs_ctrl
    import ifs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  dec_t dec,
    input  logic take,
    output ctl_t ctl
);

    fsm_e       st_q, st_d;
    logic [1:0] bidx_q, bidx_d;

    // State and operand-byte index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OP_ADR;
            bidx_q <= 2'd0;
        end else begin
            st_q   <= st_d;
            bidx_q <= bidx_d;
        end
    end

    // Next state and control lines from the current state.
    always_comb begin
        ctl    = '0;
        st_d   = st_q;
        bidx_d = bidx_q;
        case (st_q)
            ST_OP_ADR: begin ctl.ab_pc = 1'b1; st_d = ST_OP_RD; end
            ST_OP_RD:  begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_d = ST_OP_CAP; end
            ST_OP_CAP: begin ctl.db_cap = 1'b1; st_d = ST_OP_DEC; end
            ST_OP_DEC: begin
                ctl.ir_ld  = 1'b1;
                ctl.dec_db = 1'b1;
                if (dec.len == 2'd1) begin
                    st_d = ST_OP_ADR;
                end else begin
                    bidx_d = 2'd1;
                    st_d   = ST_BY_ADR;
                end
            end
            ST_BY_ADR: begin ctl.ab_pc = 1'b1; st_d = ST_BY_RD; end
            ST_BY_RD:  begin ctl.rd = 1'b1; ctl.pc_inc = 1'b1; st_d = ST_BY_CAP; end
            ST_BY_CAP: begin ctl.db_cap = 1'b1; st_d = ST_BY_MOV; end
            ST_BY_MOV: begin
                if (bidx_q == 2'd1) begin
                    ctl.b_ld = (dec.act == ACT_LDB);
                    ctl.w_ld = (dec.act != ACT_LDB);
                end else begin
                    ctl.t_ld = 1'b1;
                end
                if (bidx_q == dec.len - 2'd1) begin
                    case (dec.act)
                        ACT_LOAD: st_d = ST_MR_ADR;
                        ACT_STOR: st_d = ST_MW_ADR;
                        ACT_JUMP: st_d = ST_JMP;
                        default:  st_d = ST_OP_ADR;
                    endcase
                end else begin
                    bidx_d = bidx_q + 2'd1;
                    st_d   = ST_BY_ADR;
                end
            end
            ST_MR_ADR: begin ctl.ab_wt = 1'b1; st_d = ST_MR_RD; end
            ST_MR_RD:  begin ctl.rd = 1'b1; st_d = ST_MR_CAP; end
            ST_MR_CAP: begin ctl.db_cap = 1'b1; st_d = ST_MR_MOV; end
            ST_MR_MOV: begin ctl.w_ld = 1'b1; st_d = ST_OP_ADR; end
            ST_MW_ADR: begin ctl.ab_wt = 1'b1; ctl.db_b = 1'b1; st_d = ST_MW_WR; end
            ST_MW_WR:  begin ctl.wr = 1'b1; st_d = ST_OP_ADR; end
            ST_JMP:    begin ctl.pc_ld = take; st_d = ST_OP_ADR; end
            default:   st_d = ST_OP_ADR;
        endcase
    end

    // R3
    oper_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BY_MOV && bidx_q == 2'd2) |-> dec.len == 2'd3);

endmodule

// File: rtl/instr_fetch_seq.sv
// Module: top of the byte-serial instruction sequencer. Holds the address and
// byte holding registers, instruction register, W, TEMP and B, and wires the
// opcode table, condition test, program counter and sequencer together.
// Assumes a synchronous memory with one cycle of read latency.
module instr_fetch_seq
    import ifs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic              flag_neg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] reg_w,
    output logic [DATA_W-1:0] reg_temp,
    output logic [DATA_W-1:0] reg_b,
    output logic [ADDR_W-1:0] pc_out
);

    ctl_t              ctl;
    dec_t              dec;
    logic              take;
    logic [ADDR_W-1:0] abuf_q;
    logic [DATA_W-1:0] dbuf_q, ir_q, w_q, t_q, b_q;
    logic [7:0]        dec_in;

    assign dec_in = ctl.dec_db ? dbuf_q[7:0] : ir_q[7:0];

    ifs_decode u_dec (.opcode(dec_in), .dec(dec));

    ifs_cond u_cond (
        .cnd(dec.cnd), .flag_zero(flag_zero), .flag_carry(flag_carry),
        .flag_neg(flag_neg), .take(take)
    );

    ifs_pc #(.DATA_W(DATA_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .inc(ctl.pc_inc), .ld(ctl.pc_ld),
        .ld_lo(w_q), .ld_hi(t_q), .pc(pc_out)
    );

    ifs_ctrl u_ctrl (.clk(clk), .rst_n(rst_n), .dec(dec), .take(take), .ctl(ctl));

    // Address holding register: program counter or {TEMP, W}.
    always_ff @(posedge clk) begin
        if (!rst_n)         abuf_q <= '0;
        else if (ctl.ab_pc) abuf_q <= pc_out;
        else if (ctl.ab_wt) abuf_q <= {t_q, w_q};
    end

    // Byte holding register: captured read data or B for a store.
    always_ff @(posedge clk) begin
        if (!rst_n)          dbuf_q <= '0;
        else if (ctl.db_cap) dbuf_q <= mem_rdata;
        else if (ctl.db_b)   dbuf_q <= b_q;
    end

    // Instruction and operand registers fed from the byte holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            w_q  <= '0;
            t_q  <= '0;
            b_q  <= '0;
        end else begin
            if (ctl.ir_ld) ir_q <= dbuf_q;
            if (ctl.w_ld)  w_q  <= dbuf_q;
            if (ctl.t_ld)  t_q  <= dbuf_q;
            if (ctl.b_ld)  b_q  <= dbuf_q;
        end
    end

    assign mem_addr  = abuf_q;
    assign mem_wdata = dbuf_q;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign reg_w     = w_q;
    assign reg_temp  = t_q;
    assign reg_b     = b_q;

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R7
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == b_q && mem_addr == {t_q, w_q}));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld |=> pc_out == $past({t_q, w_q}));

    // R6
    load_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.w_ld |=> reg_w == $past(dbuf_q));

endmodule

// File: tb/test_instr_fetch_seq.sv
`timescale 1ns/100ps
module test_instr_fetch_seq;

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
        bit          chk_w;
        logic [7:0]  w;
        string       req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        flag_zero = 1'b0, flag_carry = 1'b1, flag_neg = 1'b0;
    logic [15:0] mem_addr, pc_out;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, reg_w, reg_temp, reg_b;

    logic [7:0]  mem [0:4095];
    ev_t         expq [$];
    int          errors = 0, checks = 0, cycles = 0;
    bit          done = 1'b0;
    bit          prev_rd = 1'b0, prev_wr = 1'b0;

    instr_fetch_seq i_instr_fetch_seq (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_neg(flag_neg),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .reg_w(reg_w), .reg_temp(reg_temp),
        .reg_b(reg_b), .pc_out(pc_out)
    );

    always #2.5 clk = ~clk;

    // Memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] d);
        mem[a[11:0]] = d;
    endtask

    // Driver side: push an expected bus event.
    task automatic exp_ev(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input bit cw, input logic [7:0] w, input string req);
        ev_t e;
        e.wr = wr; e.addr = a; e.data = d; e.chk_w = cw; e.w = w; e.req = req;
        expq.push_back(e);
    endtask

    task automatic exp_rd(input logic [15:0] a, input string req);
        exp_ev(1'b0, a, 8'h00, 1'b0, 8'h00, req);
    endtask

    task automatic exp_instr3(input logic [15:0] a, input string req);
        exp_rd(a, req);
        exp_rd(a + 16'd1, "R5");
        exp_rd(a + 16'd2, "R5");
    endtask

    // Monitor: compare every strobe with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_rd && mem_wr)
                check(1'b0, "R10", "both strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
            if ((mem_rd && prev_rd) || (mem_wr && prev_wr))
                check(1'b0, "R10", "strobe held", {14'd0, mem_rd, mem_wr}, 16'd0);
            if (mem_rd || mem_wr) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2", "unexpected access", mem_addr, 16'hxxxx);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    check(mem_wr == e.wr && mem_addr == e.addr, e.req, "access",
                          {mem_wr, mem_addr[14:0]}, {e.wr, e.addr[14:0]});
                    if (e.wr)
                        check(mem_wdata == e.data, e.req, "write data",
                              {8'd0, mem_wdata}, {8'd0, e.data});
                    if (e.chk_w)
                        check(reg_w == e.w, e.req, "W", {8'd0, reg_w}, {8'd0, e.w});
                end
            end
        end
        prev_rd = rst_n && mem_rd;
        prev_wr = rst_n && mem_wr;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        // Program image.
        put(16'h0000, 8'h01); put(16'h0001, 8'h34);               // W = 34
        put(16'h0002, 8'h02); put(16'h0003, 8'hA5);               // B = A5
        put(16'h0004, 8'h11); put(16'h0005, 8'h80); put(16'h0006, 8'h02); // store 0280
        put(16'h0007, 8'h10); put(16'h0008, 8'h90); put(16'h0009, 8'h02); // load 0290
        put(16'h0290, 8'h5C);
        put(16'h000A, 8'hFF);                                     // undefined
        put(16'h000B, 8'h00);                                     // undefined
        put(16'h000C, 8'h21); put(16'h000D, 8'h00); put(16'h000E, 8'h01); // JZ untaken
        put(16'h000F, 8'h23); put(16'h0010, 8'h40); put(16'h0011, 8'h00); // JC taken
        put(16'h0040, 8'h20); put(16'h0041, 8'h00); put(16'h0042, 8'h03); // JMP 0300
        put(16'h0300, 8'h22); put(16'h0301, 8'h50); put(16'h0302, 8'h00); // JNZ taken
        put(16'h0050, 8'h26); put(16'h0051, 8'h60); put(16'h0052, 8'h00); // JNEG untaken
        put(16'h0053, 8'h25); put(16'h0054, 8'h70); put(16'h0055, 8'h00); // JPOS taken
        put(16'h0070, 8'h24); put(16'h0071, 8'h80); put(16'h0072, 8'h00); // JNC untaken
        put(16'h0073, 8'h11); put(16'h0074, 8'hFF); put(16'h0075, 8'hFF); // store FFFF
        put(16'h0076, 8'h20); put(16'h0077, 8'h76); put(16'h0078, 8'h00); // JMP self

        // Expected bus traffic.
        exp_rd(16'h0000, "R1");
        exp_rd(16'h0001, "R3");
        exp_ev(1'b0, 16'h0002, 8'h00, 1'b1, 8'h34, "R4");
        exp_rd(16'h0003, "R3");
        exp_instr3(16'h0004, "R3");
        exp_ev(1'b1, 16'h0280, 8'hA5, 1'b0, 8'h00, "R7");
        exp_instr3(16'h0007, "R2");
        exp_rd(16'h0290, "R6");
        exp_ev(1'b0, 16'h000A, 8'h00, 1'b1, 8'h5C, "R6");
        exp_ev(1'b0, 16'h000B, 8'h00, 1'b1, 8'h5C, "R11");
        exp_ev(1'b0, 16'h000C, 8'h00, 1'b1, 8'h5C, "R11");
        exp_rd(16'h000D, "R5"); exp_rd(16'h000E, "R5");
        exp_instr3(16'h000F, "R9");    // JZ with zero clear falls through
        exp_instr3(16'h0040, "R8");    // JC with carry set taken
        exp_instr3(16'h0300, "R8");    // JMP taken
        exp_instr3(16'h0050, "R8");    // JNZ with zero clear taken
        exp_instr3(16'h0053, "R9");    // JNEG with negative clear falls through
        exp_instr3(16'h0070, "R8");    // JPOS with negative clear taken
        exp_instr3(16'h0073, "R9");    // JNC with carry set falls through
        exp_ev(1'b1, 16'hFFFF, 8'hA5, 1'b0, 8'h00, "R7");
        exp_instr3(16'h0076, "R2");
        exp_instr3(16'h0076, "R8");    // self jump repeats

        // Reset state (R1).
        repeat (3) @(negedge clk);
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", {14'd0, mem_rd, mem_wr}, 16'd0);
        check(pc_out == 16'h0000, "R1", "PC in reset", pc_out, 16'h0000);
        check(reg_w == 8'h00 && reg_temp == 8'h00 && reg_b == 8'h00, "R1", "regs in reset",
              {reg_w, reg_temp | reg_b}, 16'h0000);
        rst_n = 1'b1;

        wait (expq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        check(reg_w == 8'h76, "R5", "final W", {8'd0, reg_w}, 16'h0076);
        check(reg_temp == 8'h00, "R5", "final TEMP", {8'd0, reg_temp}, 16'h0000);
        check(reg_b == 8'hA5, "R4", "final B", {8'd0, reg_b}, 16'h00A5);
        check(mem[12'h280] == 8'hA5, "R7", "stored byte", {8'd0, mem[12'h280]}, 16'h00A5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule